// File: doc/BRIEF.md
# Data Address Generator with Post-Update and Size Scaling

This block forms the 24-bit data-memory address for a single load or store and, for the post-modifying modes, the new value of the pointer register. Each request carries a 4-bit mode code, a 2-bit access size, a flag marking the destination of a byte memory-to-memory move, and the operands the mode needs: the selected pointer, the offset register, the stack pointer and the immediate field of the instruction. Offsets are sign-, zero- or one-extended as the mode demands. They are then scaled to the access size: doubled for long accesses, halved (rounding toward minus infinity) for byte accesses. All arithmetic wraps modulo 2^24.

Requests and results move over a valid/ready pair at each side. A request is taken on any edge where `in_valid` and `in_ready` are both high. With the default `REG_OUT = 1` the result appears one cycle later. It stays on the outputs, unchanged, for as long as `out_valid` is high and `out_ready` is low. `in_ready` is high whenever the output stage is empty or is being drained in the same cycle. With `REG_OUT = 0` the result path is purely combinational and the handshake passes straight through. A mode/size combination that is not allowed raises `err`, forces the address to zero and suppresses write-back.

Top module: `agu_top`

## Requirements
- R1: Modes 0 (plain), 1 (post-increment) and 2 (post-decrement) output the pointer `rn` as the address. Mode 1 writes back `rn`+1 for word and `rn`+2 for long; mode 2 writes back `rn`-1 or `rn`-2. Mode 0 does no write-back.
- R2: Mode 3 (post-update by N) outputs `rn` and writes back `rn` plus the scaled offset. Mode 4 (indexed by N) outputs `rn` plus that offset and does no write-back. The offset is `nreg[15:0]` sign-extended, and it is doubled for long accesses.
- R3: Mode 5 adds `imm[2:0]` to `rn` as an unsigned value from 0 to 7, halved for byte accesses.
- R4: Mode 6 adds `imm[5:0]` to `sp` after one-extension, so the result is `sp` - (64 - `imm[5:0]`). The offset is doubled for long and halved (floor) for byte. Mode 7 does the same with `imm[2:0]` (`sp` - (8 - `imm[2:0]`)).
- R5: Mode 8 adds `imm[15:0]` and mode 9 adds `imm[23:0]` to `rn`, both as signed values. The offset is doubled for long and halved (floor) for byte.
- R6: Mode 10 outputs `imm[5:0]` zero-extended. Mode 11 outputs 0x00FFC0 OR `imm[5:0]`. The upper immediate bits have no effect in either mode.
- R7: Mode 12 outputs `imm[15:0]` zero-extended and mode 13 outputs `imm[23:0]`, both doubled for long accesses. A byte access to these modes uses the field unscaled, and is legal only when `mm_byte_dst` is 1.
- R8: Size codes are 0 byte, 1 word, 2 long and 3 reserved. Legal sizes per mode: 0 to 4 word/long; 5 and 7 byte/word; 6, 8 and 9 all three; 10 and 11 word only; 12 and 13 word/long, plus byte when `mm_byte_dst` is 1; modes 14 and 15 none. An illegal request gives `err`=1, `ea`=0, `wb_data`=0 and `wb_en`=0. `wb_en` is 1 only for legal modes 1 to 3, and `wb_data` is 0 whenever `wb_en` is 0.
- R9: Address and write-back sums wrap modulo 2^24.
- R10: `in_ready` = !`out_valid` || `out_ready`. While `out_valid` is high and `out_ready` is low, all result outputs hold their values.
- R11: During and after reset, `out_valid` is 0 and `in_ready` is 1. With `REG_OUT` = 1, an accepted request gives `out_valid` = 1 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be taken |
| mode | input | 4 | Addressing-mode code |
| size | input | 2 | Access size code |
| mm_byte_dst | input | 1 | Request is the destination of a byte memory-to-memory move |
| rn | input | 24 | Selected pointer register |
| nreg | input | 24 | Offset register (low 16 bits used) |
| sp | input | 24 | Stack pointer |
| imm | input | 24 | Immediate offset or absolute field |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| ea | output | 24 | Effective address |
| wb_data | output | 24 | Pointer write-back value |
| wb_en | output | 1 | Pointer write-back enable |
| err | output | 1 | Illegal mode/size combination |

## Verification
The assertions assume that `mode`, `size`, `rn` and `imm` carry defined values whenever `in_valid` is high, and that the consumer may hold `out_ready` low for any number of cycles. The bench meets these assumptions by driving every request field to a known value on a falling edge, before raising `in_valid`, and by changing fields only on falling edges. It covers every mode code, including the reserved ones, and every size code, so illegal combinations are exercised rather than avoided. Back-pressure is applied while a second request waits at the input.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [3:0] {
    AM_PLAIN   = 4'd0,
    AM_POSTINC = 4'd1,
    AM_POSTDEC = 4'd2,
    AM_POSTN   = 4'd3,
    AM_IDXN    = 4'd4,
    AM_IDX3    = 4'd5,
    AM_SPOFF6  = 4'd6,
    AM_SPOFF3  = 4'd7,
    AM_IDX16   = 4'd8,
    AM_IDX24   = 4'd9,
    AM_ABS6    = 4'd10,
    AM_PERI6   = 4'd11,
    AM_ABS16   = 4'd12,
    AM_ABS24   = 4'd13,
    AM_RSV14   = 4'd14,
    AM_RSV15   = 4'd15
  } agu_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSV  = 2'd3
  } agu_size_e;

  // Which access sizes each mode accepts (R8).
  function automatic logic access_legal(agu_mode_e m, agu_size_e s, logic mm_dst);
    logic b, w, l;
    b = (s == SZ_BYTE);
    w = (s == SZ_WORD);
    l = (s == SZ_LONG);
    case (m)
      AM_PLAIN, AM_POSTINC, AM_POSTDEC, AM_POSTN, AM_IDXN: return w | l;
      AM_IDX3, AM_SPOFF3:                                  return w | b;
      AM_SPOFF6, AM_IDX16, AM_IDX24:                       return b | w | l;
      AM_ABS6, AM_PERI6:                                   return w;
      AM_ABS16, AM_ABS24:                                  return w | l | (b & mm_dst);
      default:                                             return 1'b0;
    endcase
  endfunction

  function automatic logic is_post_update(agu_mode_e m);
    return (m == AM_POSTINC) || (m == AM_POSTDEC) || (m == AM_POSTN);
  endfunction

  function automatic logic uses_sp(agu_mode_e m);
    return (m == AM_SPOFF6) || (m == AM_SPOFF3);
  endfunction

endpackage

// File: rtl/agu_offset.sv
module agu_offset
  import agu_pkg::*;
#(
  parameter int AW  = 24,
  parameter int NW  = 16,
  parameter int SLW = 6,
  parameter int SSW = 3
) (
  input  agu_mode_e        mode_i,
  input  agu_size_e        size_i,
  input  logic [NW-1:0]    nlow_i,
  input  logic [AW-1:0]    imm_i,
  output logic [AW-1:0]    off_o
);

  logic [AW-1:0] raw;

  // Select and extend the unscaled offset for the mode.
  always_comb begin
    case (mode_i)
      AM_POSTINC:         raw = AW'(1);
      AM_POSTDEC:         raw = '1;
      AM_POSTN, AM_IDXN:  raw = {{(AW-NW){nlow_i[NW-1]}}, nlow_i};
      AM_IDX3:            raw = {{(AW-SSW){1'b0}}, imm_i[SSW-1:0]};
      AM_SPOFF6:          raw = {{(AW-SLW){1'b1}}, imm_i[SLW-1:0]};
      AM_SPOFF3:          raw = {{(AW-SSW){1'b1}}, imm_i[SSW-1:0]};
      AM_IDX16:           raw = {{(AW-NW){imm_i[NW-1]}}, imm_i[NW-1:0]};
      AM_IDX24:           raw = imm_i;
      default:            raw = '0;
    endcase
  end

  // Scale to the access size: long doubles, byte halves toward minus infinity.
  always_comb begin
    case (size_i)
      SZ_LONG: off_o = {raw[AW-2:0], 1'b0};
      SZ_BYTE: off_o = {raw[AW-1], raw[AW-1:1]};
      default: off_o = raw;
    endcase
  end

endmodule

// File: rtl/agu_core.sv
module agu_core
  import agu_pkg::*;
#(
  parameter int            AW        = 24,
  parameter int            NW        = 16,
  parameter logic [AW-1:0] PERI_BASE = 24'h00FFC0
) (
  input  logic [3:0]     mode_i,
  input  logic [1:0]     size_i,
  input  logic           mm_dst_i,
  input  logic [AW-1:0]  rn_i,
  input  logic [NW-1:0]  nlow_i,
  input  logic [AW-1:0]  sp_i,
  input  logic [AW-1:0]  imm_i,
  output logic [AW-1:0]  ea_o,
  output logic [AW-1:0]  wb_o,
  output logic           wb_en_o,
  output logic           err_o
);

  localparam int SHORT_W = 6;

  agu_mode_e     md;
  agu_size_e     sz;
  logic          legal;
  logic [AW-1:0] off;
  logic [AW-1:0] base;
  logic [AW-1:0] sum;
  logic [AW-1:0] abs_raw;
  logic [AW-1:0] abs_addr;

  assign md    = agu_mode_e'(mode_i);
  assign sz    = agu_size_e'(size_i);
  assign legal = access_legal(md, sz, mm_dst_i);

  agu_offset #(.AW(AW), .NW(NW)) u_off (
    .mode_i (md),
    .size_i (sz),
    .nlow_i (nlow_i),
    .imm_i  (imm_i),
    .off_o  (off)
  );

  assign base = uses_sp(md) ? sp_i : rn_i;
  assign sum  = base + off;

  always_comb begin
    case (md)
      AM_ABS6:  abs_raw = {{(AW-SHORT_W){1'b0}}, imm_i[SHORT_W-1:0]};
      AM_PERI6: abs_raw = PERI_BASE | {{(AW-SHORT_W){1'b0}}, imm_i[SHORT_W-1:0]};
      AM_ABS16: abs_raw = {{(AW-NW){1'b0}}, imm_i[NW-1:0]};
      default:  abs_raw = imm_i;
    endcase
  end

  assign abs_addr = (sz == SZ_LONG) ? {abs_raw[AW-2:0], 1'b0} : abs_raw;

  always_comb begin
    ea_o    = '0;
    wb_o    = '0;
    wb_en_o = 1'b0;
    err_o   = !legal;
    if (legal) begin
      case (md)
        AM_PLAIN:                     ea_o = rn_i;
        AM_POSTINC, AM_POSTDEC,
        AM_POSTN:                     ea_o = rn_i;
        AM_ABS6, AM_PERI6,
        AM_ABS16, AM_ABS24:           ea_o = abs_addr;
        default:                      ea_o = sum;
      endcase
      if (is_post_update(md)) begin
        wb_o    = sum;
        wb_en_o = 1'b1;
      end
    end
  end

endmodule

// File: rtl/agu_outreg.sv
module agu_outreg #(
  parameter int W       = 50,
  parameter bit REG_OUT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  generate
    if (REG_OUT) begin : g_reg
      logic         vld_q;
      logic [W-1:0] dat_q;

      assign in_ready  = !vld_q || out_ready;
      assign out_valid = vld_q;
      assign out_data  = dat_q;

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          vld_q <= 1'b0;
        end else if (in_ready) begin
          vld_q <= in_valid;
        end
      end

      always_ff @(posedge clk) begin
        if (in_valid && in_ready) begin
          dat_q <= in_data;
        end
      end
    end else begin : g_wire
      logic clk_rst_unused;
      assign clk_rst_unused = clk ^ rst_n;
      assign in_ready       = out_ready;
      assign out_valid      = in_valid;
      assign out_data       = in_data;
    end
  endgenerate

endmodule

// File: rtl/agu_top.sv
module agu_top #(
  parameter int            AW        = 24,
  parameter int            NW        = 16,
  parameter logic [AW-1:0] PERI_BASE = 24'h00FFC0,
  parameter bit            REG_OUT   = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    mode,
  input  logic [1:0]    size,
  input  logic          mm_byte_dst,
  input  logic [AW-1:0] rn,
  input  logic [AW-1:0] nreg,
  input  logic [AW-1:0] sp,
  input  logic [AW-1:0] imm,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [AW-1:0] ea,
  output logic [AW-1:0] wb_data,
  output logic          wb_en,
  output logic          err
);

  localparam int PW = 2 * AW + 2;

  logic [AW-1:0] c_ea;
  logic [AW-1:0] c_wb;
  logic          c_wb_en;
  logic          c_err;
  logic [PW-1:0] pay_in;
  logic [PW-1:0] pay_out;
  logic          nreg_hi_unused;

  assign nreg_hi_unused = ^nreg[AW-1:NW];

  agu_core #(.AW(AW), .NW(NW), .PERI_BASE(PERI_BASE)) u_core (
    .mode_i   (mode),
    .size_i   (size),
    .mm_dst_i (mm_byte_dst),
    .rn_i     (rn),
    .nlow_i   (nreg[NW-1:0]),
    .sp_i     (sp),
    .imm_i    (imm),
    .ea_o     (c_ea),
    .wb_o     (c_wb),
    .wb_en_o  (c_wb_en),
    .err_o    (c_err)
  );

  assign pay_in = {c_err, c_wb_en, c_wb, c_ea};

  agu_outreg #(.W(PW), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (pay_in),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (pay_out)
  );

  assign {err, wb_en, wb_data, ea} = pay_out;

endmodule

// File: rtl/agu_chk.sv
module agu_chk
  import agu_pkg::*;
#(
  parameter int AW      = 24,
  parameter bit REG_OUT = 1'b1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    mode,
  input logic [1:0]    size,
  input logic [AW-1:0] rn,
  input logic [AW-1:0] imm,
  input logic          out_valid,
  input logic          out_ready,
  input logic [AW-1:0] ea,
  input logic [AW-1:0] wb_data,
  input logic          wb_en,
  input logic          err
);

  // R8
  err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && err) |-> (!wb_en && ea == '0 && wb_data == '0));

  // R10
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  generate
    if (REG_OUT) begin : g_seq
      // R10
      stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
          (out_valid && $stable(ea) && $stable(wb_data) && $stable(wb_en) && $stable(err)));

      // R11
      accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

      // R1
      post_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && (mode == AM_POSTINC || mode == AM_POSTDEC)
          && (size == SZ_WORD || size == SZ_LONG))
        |=> (ea == $past(rn) && wb_en && !err));

      // R6
      short_abs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && mode == AM_ABS6 && size == SZ_WORD)
        |=> (ea == {{(AW-6){1'b0}}, $past(imm[5:0])} && !wb_en));
    end
  endgenerate

endmodule

bind agu_top agu_chk #(.AW(AW), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/agu_top_tb.sv
module agu_top_tb;

  localparam longint MOD = 64'd16777216;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [3:0]  mode = '0;
  logic [1:0]  size = '0;
  logic        mm_byte_dst = 1'b0;
  logic [23:0] rn = '0, nreg = '0, sp = '0, imm = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [23:0] ea, wb_data;
  logic        wb_en, err;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  agu_top u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .mode(mode), .size(size), .mm_byte_dst(mm_byte_dst),
    .rn(rn), .nreg(nreg), .sp(sp), .imm(imm),
    .out_valid(out_valid), .out_ready(out_ready),
    .ea(ea), .wb_data(wb_data), .wb_en(wb_en), .err(err)
  );

  function automatic longint wrap24(longint v);
    return ((v % MOD) + MOD) % MOD;
  endfunction

  function automatic longint sext(longint v, int w);
    longint m = longint'(1) << w;
    longint t = v & (m - 1);
    return (t >= m / 2) ? t - m : t;
  endfunction

  function automatic longint sized(longint v, int s);
    if (s == 2) return v * 2;
    if (s == 0) return (v >= 0) ? v / 2 : -((1 - v) / 2);
    return v;
  endfunction

  function automatic string mode_tag(int m);
    if (m <= 2) return "R1";
    if (m <= 4) return "R2";
    if (m == 5) return "R3";
    if (m <= 7) return "R4";
    if (m <= 9) return "R5";
    if (m <= 11) return "R6";
    return "R7";
  endfunction

  task automatic model(input int m, input int s, input bit mm, input longint rv,
                       input longint nv, input longint spv, input longint iv,
                       output bit e, output longint xea, output longint xwb, output bit we);
    bit ok;
    longint a;
    ok = 1'b0;
    if (s != 3) begin
      if (m <= 4)                 ok = (s != 0);
      else if (m == 5 || m == 7)  ok = (s != 2);
      else if (m == 6 || m == 8 || m == 9) ok = 1'b1;
      else if (m == 10 || m == 11) ok = (s == 1);
      else if (m == 12 || m == 13) ok = (s != 0) || mm;
    end
    e = !ok; xea = 0; xwb = 0; we = 1'b0;
    if (!ok) return;
    case (m)
      0: xea = rv;
      1: begin xea = rv; xwb = wrap24(rv + ((s == 2) ? 2 : 1)); we = 1'b1; end
      2: begin xea = rv; xwb = wrap24(rv - ((s == 2) ? 2 : 1)); we = 1'b1; end
      3: begin xea = rv; xwb = wrap24(rv + sized(sext(nv, 16), s)); we = 1'b1; end
      4: xea = wrap24(rv + sized(sext(nv, 16), s));
      5: xea = wrap24(rv + sized(iv & 7, s));
      6: xea = wrap24(spv + sized((iv & 63) - 64, s));
      7: xea = wrap24(spv + sized((iv & 7) - 8, s));
      8: xea = wrap24(rv + sized(sext(iv, 16), s));
      9: xea = wrap24(rv + sized(sext(iv, 24), s));
      10: xea = iv & 63;
      11: xea = 64'h00FFC0 + (iv & 63);
      12: begin a = iv & 64'hFFFF;   xea = (s == 2) ? wrap24(a * 2) : a; end
      default: begin a = iv & 64'hFFFFFF; xea = (s == 2) ? wrap24(a * 2) : a; end
    endcase
  endtask

  task automatic apply(input int m, input int s, input bit mm, input longint rv,
                       input longint nv, input longint spv, input longint iv, input bit wcase);
    bit e, we;
    longint xea, xwb;
    string tag;
    model(m, s, mm, rv, nv, spv, iv, e, xea, xwb, we);
    tag = e ? "R8" : (wcase ? "R9" : mode_tag(m));
    @(negedge clk);
    mode = 4'(m); size = 2'(s); mm_byte_dst = mm;
    rn = 24'(rv); nreg = 24'(nv); sp = 24'(spv); imm = 24'(iv);
    in_valid = 1'b1; out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    n_vec++;
    if (out_valid !== 1'b1 || ea !== 24'(xea) || wb_data !== 24'(xwb) ||
        wb_en !== we || err !== e) begin
      n_bad++;
      $display("FAIL %s mode=%0d size=%0d mm=%0b: got v=%0b ea=%h wb=%h we=%0b err=%0b, expected v=1 ea=%h wb=%h we=%0b err=%0b",
               tag, m, s, mm, out_valid, ea, wb_data, wb_en, err,
               24'(xea), 24'(xwb), we, e);
    end
  endtask

  task automatic chk(input bit cond, input string tag, input string what);
    n_vec++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s %s: got v=%0b rdy=%0b ea=%h", tag, what, out_valid, in_ready, ea);
    end
  endtask

  longint p_rn[6]  = '{64'hFFFFFE, 64'h000000, 64'h123456, 64'h400000, 64'h00ABCD, 64'h7FFFF0};
  longint p_n[6]   = '{64'h127FFF, 64'h008000, 64'hFF0010, 64'h00FFFF, 64'h551234, 64'h000001};
  longint p_sp[6]  = '{64'h000003, 64'h000000, 64'h00F000, 64'h7FFFFF, 64'h001000, 64'h800000};
  longint p_imm[6] = '{64'h7FFFFF, 64'h800000, 64'h00FFFF, 64'h000001, 64'h0C0C3F, 64'hF12345};
  int short_modes[5] = '{5, 6, 7, 10, 11};

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11: reset state
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R11", "state during reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R11", "idle after reset");

    // Sweep every mode, size and byte-move flag over operand patterns (R1..R9).
    for (int p = 0; p < 6; p++)
      for (int m = 0; m < 16; m++)
        for (int s = 0; s < 4; s++)
          for (int mm = 0; mm < 2; mm++)
            apply(m, s, bit'(mm), p_rn[p], p_n[p], p_sp[p], p_imm[p], p == 0);

    // Exhaustive short fields, junk in upper immediate bits (R3, R4, R6).
    for (int k = 0; k < 5; k++)
      for (int s = 0; s < 3; s++)
        for (int f = 0; f < 64; f++)
          apply(short_modes[k], s, 1'b0, 64'h3A0010, 64'h0, 64'h000020,
                64'hABCDC0 | longint'(f), 1'b0);

    // R10: back-pressure with a second request waiting.
    @(negedge clk);
    mode = 4'd8; size = 2'd1; rn = 24'h000100; imm = 24'h000010;
    in_valid = 1'b1; out_ready = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b1 && ea === 24'h000110, "R10", "first result presented");
    mode = 4'd13; imm = 24'h123456;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      chk(out_valid === 1'b1 && in_ready === 1'b0 && ea === 24'h000110, "R10", "held under stall");
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid === 1'b1 && ea === 24'h123456, "R10", "second result after release");
    @(negedge clk);
    chk(out_valid === 1'b0 && in_ready === 1'b1, "R11", "drained");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule